// File: doc/BRIEF.md
# Successive Approximation Conversion Sequencer

This block is the digital control for a 12-bit successive approximation converter. It watches the chip-select and read strobes for a start request. When one arrives it runs a fixed 13-cycle binary search. At each step it drives a trial code to an external DAC and uses a one-bit comparator answer to keep or drop the bit under test. The search works from the most significant bit down to the least significant bit. When the search ends, the finished word moves into a separate output latch that a host reads.

The strobes are sampled on the falling clock edge. A start sampled there is acted on at the next rising edge, so a strobe that falls just after a rising edge gives a fixed alignment. The sequencer moves through three named states:

- **IDLE** waits for a start. On a start, the transition IDLE→TRIAL loads the trial register with only the MSB set.
- **TRIAL** makes one bit decision per rising edge. Its self-loop TRIAL→TRIAL handles bits 11 to 1. After the LSB decision it takes the transition TRIAL→XFER.
- **XFER** is the final busy cycle. Its transition XFER→IDLE copies the trial word into the output latch and releases busy.

Top module: `sar_conv_seq`

## Requirements
- R1: A conversion starts only when the falling-edge sample sees chip-select and read both low, and the previous sample did not. Either strobe low on its own never starts one.
- R2: If the high-byte enable is high in the sample where the strobe pair first reads low, no conversion starts. Lowering it afterwards does not start one either.
- R3: `data_oe` is 0 after reset. It becomes 1 on the first rising edge of a conversion and then stays 1.
- R4: `busy_n` goes low on the first rising edge after a sampled start and stays low for exactly 13 clock cycles.
- R5: After the first rising edge, `dac_code` holds only bit 11 set. The MSB decision is made on the second rising edge. The remaining bits are decided one per rising edge, from bit 10 down to bit 0. A tested bit stays set when `cmp_in` is 1, meaning the input is at or above the DAC code. On each decision the next lower bit is set for trial.
- R6: A start request that arrives while `busy_n` is low is ignored. This includes one in the last busy cycle. It neither restarts nor aborts the running conversion.
- R7: At completion, `data_out` equals the largest code whose DAC value does not exceed the input, as seen through an ideal comparator.
- R8: `data_out` changes only on the rising edge where `busy_n` returns high. Throughout a conversion it holds the previous result.
- R9: After reset, `busy_n` is 1 and both `dac_code` and `data_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip-select strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| hben | input | 1 | High-byte enable; must be low when the strobe pair falls |
| cmp_in | input | 1 | Comparator answer: 1 when the input is at or above the DAC code |
| dac_code | output | 12 | Trial code for the external DAC |
| busy_n | output | 1 | Low while a conversion runs |
| data_out | output | 12 | Output latch holding the last completed result |
| data_oe | output | 1 | Tri-state enable for the data outputs |

## Verification
A new start request can land in the same cycle as the completion transfer, XFER→IDLE. The bench provokes this by releasing the strobes during a conversion and dropping them again right after the thirteenth rising edge. It then checks that `busy_n` stays high for several cycles and that the latch still holds the finished word. A second restrike, placed in the middle of a conversion, checks that the busy length and the result are not disturbed. Every 12-bit input code is also converted back to back, so the first strobe after each completion is accepted.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_TRIAL = 2'd1,
        ST_XFER  = 2'd2
    } sar_state_e;

endpackage

// File: rtl/sar_start_detect.sv
module sar_start_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic rd_n,
    input  logic hben,
    input  logic accept,
    output logic start_pend
);

    logic strb_now;
    logic strb_q;
    logic start_q;

    assign strb_now = ~cs_n & ~rd_n;

    // Strobes sampled on the falling edge; the reset value demands a fresh fall
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strb_q  <= 1'b1;
            start_q <= 1'b0;
        end else begin
            strb_q  <= strb_now;
            start_q <= strb_now & ~strb_q & ~hben & accept;
        end
    end

    assign start_pend = start_q;

    // R6: no pending start can be seen by a busy sequencer
    p_no_start_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |-> !start_pend);

endmodule

// File: rtl/sar_trial_fsm.sv
module sar_trial_fsm
    import sar_seq_pkg::*;
#(
    parameter int WIDTH = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             cmp_in,
    output logic [WIDTH-1:0] trial,
    output logic             busy_n,
    output logic             xfer,
    output logic             oe
);

    localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(WIDTH - 1);
    localparam logic [WIDTH-1:0] MSB_ONE = {1'b1, {(WIDTH-1){1'b0}}};

    sar_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic [WIDTH-1:0] trial_q, trial_d;
    logic             oe_q, oe_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            trial_q <= '0;
            oe_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            trial_q <= trial_d;
            oe_q    <= oe_d;
        end
    end

    // Next state and trial update
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        trial_d = trial_q;
        oe_d    = oe_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_TRIAL;
                    idx_d   = TOP_IDX;
                    trial_d = MSB_ONE;
                    oe_d    = 1'b1;
                end
            end
            ST_TRIAL: begin
                for (int i = 0; i < WIDTH; i++) begin
                    if (i == int'(idx_q))
                        trial_d[i] = cmp_in;
                    if (i + 1 == int'(idx_q))
                        trial_d[i] = 1'b1;
                end
                if (idx_q == '0) begin
                    state_d = ST_XFER;
                end else begin
                    idx_d = idx_q - 1'b1;
                end
            end
            ST_XFER: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Outputs
    always_comb begin
        busy_n = (state_q == ST_IDLE);
        xfer   = (state_q == ST_XFER);
        trial  = trial_q;
        oe     = oe_q;
    end

    p_first_trial_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start) |=> (trial_q == MSB_ONE));

    p_release_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_XFER) |=> busy_n);

    p_no_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TRIAL) |=> (state_q == ST_TRIAL || state_q == ST_XFER));

    p_oe_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        oe_q |=> oe_q);

    p_low_bits_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start) |=> ($countones(trial_q) == 1));

endmodule

// File: rtl/sar_out_latch.sv
module sar_out_latch #(
    parameter int WIDTH = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] q_r;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q_r <= '0;
        else if (load)
            q_r <= d;
    end

    assign q = q_r;

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q_r));

endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq #(
    parameter int WIDTH = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             rd_n,
    input  logic             hben,
    input  logic             cmp_in,
    output logic [WIDTH-1:0] dac_code,
    output logic             busy_n,
    output logic [WIDTH-1:0] data_out,
    output logic             data_oe
);

    logic             start_pend;
    logic             busy_n_w;
    logic             xfer_w;
    logic [WIDTH-1:0] trial_w;

    sar_start_detect u_start (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .rd_n       (rd_n),
        .hben       (hben),
        .accept     (busy_n_w),
        .start_pend (start_pend)
    );

    sar_trial_fsm #(.WIDTH(WIDTH)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start_pend),
        .cmp_in (cmp_in),
        .trial  (trial_w),
        .busy_n (busy_n_w),
        .xfer   (xfer_w),
        .oe     (data_oe)
    );

    sar_out_latch #(.WIDTH(WIDTH)) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (xfer_w),
        .d     (trial_w),
        .q     (data_out)
    );

    assign dac_code = trial_w;
    assign busy_n   = busy_n_w;

    // R8: the latch moves only on the edge that releases busy
    p_latch_at_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(data_out) |-> $rose(busy_n));

endmodule

// File: tb/tb_sar_conv_seq.sv
module tb_sar_conv_seq;

    localparam int CLK_PERIOD = 10;
    localparam int W = 12;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cs_n = 1'b1;
    logic         rd_n = 1'b1;
    logic         hben = 1'b0;
    logic [W-1:0] ain = '0;
    logic         cmp_in;
    logic [W-1:0] dac_code;
    logic         busy_n;
    logic [W-1:0] data_out;
    logic         data_oe;

    int           n_chk = 0;
    int           n_bad = 0;
    logic [W-1:0] prev = '0;
    int           cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Ideal comparator
    assign cmp_in = (dac_code <= ain);

    sar_conv_seq #(.WIDTH(W)) dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .hben(hben),
        .cmp_in(cmp_in), .dac_code(dac_code), .busy_n(busy_n),
        .data_out(data_out), .data_oe(data_oe)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Runs one conversion; strike_at>0 re-drops the strobes just after that rising edge
    task automatic convert(input int code, input int strike_at, input bit detail);
        int n;
        @(posedge clk); #1;
        ain = W'(code); hben = 1'b0; cs_n = 1'b0; rd_n = 1'b0;
        @(posedge clk); #2;
        n = 1;
        chk("R4 busy low on first edge", int'(busy_n), 0);
        chk("R3 oe on", int'(data_oe), 1);
        if (detail) chk("R5 MSB trial", int'(dac_code), 1 << (W-1));
        if (strike_at > 0) begin cs_n = 1'b1; rd_n = 1'b1; end
        while (busy_n == 1'b0 && n < 40) begin
            @(posedge clk);
            if (n + 1 == strike_at) begin #1; cs_n = 1'b0; rd_n = 1'b0; #1; end
            else #2;
            n++;
            if (detail && n == 2) begin
                chk("R5 MSB decision", int'(dac_code[W-1]), int'(code >= (1 << (W-1))));
                chk("R5 next trial bit", int'(dac_code[W-2]), 1);
            end
            if (n == 7) chk("R8 latch holds", int'(data_out), int'(prev));
        end
        chk("R4 busy length 13", n - 1, 13);
        chk("R7 result", int'(data_out), code);
        prev = W'(code);
        if (strike_at > 0) begin
            repeat (4) begin
                @(posedge clk); #2;
                chk("R6 restrike ignored", int'(busy_n), 1);
            end
            chk("R6 result kept", int'(data_out), code);
        end
        cs_n = 1'b1; rd_n = 1'b1;
        @(posedge clk);
    endtask

    // Watchdog
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 190000) begin
                n_bad++;
                $display("FAIL watchdog actual=%0d expected=<190000", cyc);
                $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        chk("R9 busy_n reset", int'(busy_n), 1);
        chk("R3 oe reset", int'(data_oe), 0);
        chk("R9 dac reset", int'(dac_code), 0);
        chk("R9 data reset", int'(data_out), 0);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);

        // R1: a single strobe never starts
        #1; cs_n = 1'b0;
        repeat (3) begin @(posedge clk); #2; chk("R1 cs alone", int'(busy_n), 1); end
        cs_n = 1'b1; rd_n = 1'b0;
        repeat (3) begin @(posedge clk); #2; chk("R1 rd alone", int'(busy_n), 1); end
        rd_n = 1'b1;
        @(posedge clk);

        // R2: high-byte enable high at the strobe edge blocks, lowering later does not start
        #1; hben = 1'b1; cs_n = 1'b0; rd_n = 1'b0;
        repeat (3) begin @(posedge clk); #2; chk("R2 hben blocks", int'(busy_n), 1); end
        hben = 1'b0;
        repeat (3) begin @(posedge clk); #2; chk("R2 late hben low", int'(busy_n), 1); end
        chk("R3 oe still off", int'(data_oe), 0);
        cs_n = 1'b1; rd_n = 1'b1;
        @(posedge clk);

        // R5 detail on edge codes
        convert(12'hFFF, 0, 1'b1);
        convert(12'h000, 0, 1'b1);
        convert(12'h800, 0, 1'b1);
        convert(12'h7FF, 0, 1'b1);

        // R6: restrike mid-conversion and in the completion cycle
        convert(12'hA5C, 5, 1'b0);
        convert(12'h3C1, 13, 1'b0);
        convert(12'h555, 0, 1'b1);

        // R7: every code, back to back
        for (int c = 0; c < (1 << W); c++) begin
            convert(c, 0, 1'b0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule